// File: doc/BRIEF.md
# Rotating Ring-Priority Bus Arbiter

This block decides which of several processors may drive one shared system bus. Each processor raises a request line. Priority is handed along a ring of small per-unit cells: a cell that is not requesting passes the token on, and the first requesting cell that holds the token is the one selected. The ring has no fixed head. The position just after the unit that last released the bus becomes the head, so the unit that just released the bus is now last in line. The ring has no central controller state apart from that head position and the owner record.

A selected unit does not take the bus while the shared busy line is active. The current owner always finishes its transfer and signals completion with a one-cycle `done` pulse, even if a higher-priority unit is waiting. When the owner completes, the busy line drops. On the next clock the waiting unit that is first in ring order claims the bus. Grant and busy are control levels, not a data stream, so they carry no valid/ready handshake. The bus transfer itself is outside this block.

Top module: `rot_chain_arbiter`

## Requirements
- R1: After reset no grant is active, busy is low, and unit 0 is the head of the ring, so unit 0 wins when every unit requests.
- R2: When busy is low and at least one unit requests at a clock edge, exactly one grant and busy rise at that edge.
- R3: The unit selected is the first requesting unit met when counting upward from the head index and wrapping from N-1 to 0. Units that are not requesting pass priority on.
- R4: At most one grant bit is high in any cycle, and busy is high exactly when some grant bit is high.
- R5: An owner keeps its grant at every edge where it does not assert its own done bit, whatever the other requests are. A higher-priority request never preempts it.
- R6: The owner asserting its done bit at an edge clears its grant and busy at that edge. No unit is granted at that same edge. A waiting unit is granted at the following edge.
- R7: A done bit from a unit that does not own the bus, or any done while the bus is idle, has no effect on grant or busy.
- R8: After unit k releases the bus, the head becomes unit k+1 (modulo N), so unit k has the lowest priority in the next selection.
- R9: A unit that keeps requesting sees at most N-1 ownerships start for other units before it is granted.
- R10: The ring wraps. When unit N-1 releases, unit 0 becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_UNITS | Bus request, one bit per unit |
| done | input | N_UNITS | Release pulse, one bit per unit; only the owner's bit counts |
| grant | output | N_UNITS | One-hot bus ownership |
| busy | output | 1 | Shared bus-busy line |

## Verification
A request sampled at an edge while busy is low shows up as a grant and busy right after that same edge. A done from the owner clears grant and busy after the edge that samples it, and the next owner appears one edge later. The bench drives `req` and `done` on the falling edge. A reference model, written from the requirements, is advanced once per rising edge. The outputs are compared on the next falling edge, so every comparison sees exactly one register update. Fairness is measured from the observed grants, by counting new ownerships given to other units while a request stays high.

// File: rtl/rca_pkg.sv
package rca_pkg;
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rca_prio_cell.sv
module rca_prio_cell (
  input  logic pri_in,
  input  logic want,
  output logic pri_out,
  output logic chosen
);
  assign pri_out = pri_in & ~want;
  assign chosen  = pri_in & want;
endmodule

// File: rtl/rca_ring.sv
module rca_ring #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W = rca_pkg::idx_bits(N_UNITS)
) (
  input  logic [IDX_W-1:0]   head,
  input  logic [N_UNITS-1:0] want,
  output logic [N_UNITS-1:0] pick
);
  logic [N_UNITS-1:0] want_pos;
  logic [N_UNITS-1:0] pick_pos;
  logic [N_UNITS:0]   token;

  function automatic logic [IDX_W-1:0] unit_at(input logic [IDX_W-1:0] h, input int unsigned k);
    logic [IDX_W:0] s;
    s = {1'b0, h} + (IDX_W+1)'(k);
    if (s >= (IDX_W+1)'(N_UNITS)) s = s - (IDX_W+1)'(N_UNITS);
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    for (int k = 0; k < N_UNITS; k++) want_pos[k] = want[unit_at(head, k)];
  end

  assign token[0] = 1'b1;

  generate
    for (genvar k = 0; k < N_UNITS; k++) begin : g_cell
      rca_prio_cell u_cell (
        .pri_in (token[k]),
        .want   (want_pos[k]),
        .pri_out(token[k+1]),
        .chosen (pick_pos[k])
      );
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int k = 0; k < N_UNITS; k++) pick[unit_at(head, k)] = pick_pos[k];
  end
endmodule

// File: rtl/rca_owner.sv
module rca_owner #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W = rca_pkg::idx_bits(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] pick,
  input  logic [N_UNITS-1:0] done,
  output logic [N_UNITS-1:0] own,
  output logic               busy_q,
  output logic [IDX_W-1:0]   head
);
  logic [N_UNITS-1:0] rel_vec;
  logic               rel;
  logic               take;
  logic [IDX_W-1:0]   rel_idx;
  logic [IDX_W-1:0]   next_head;

  assign rel_vec = own & done;
  assign rel     = |rel_vec;
  assign take    = ~busy_q & (|pick);

  always_comb begin
    rel_idx = '0;
    for (int i = 0; i < N_UNITS; i++) if (rel_vec[i]) rel_idx = IDX_W'(i);
    next_head = (rel_idx == IDX_W'(N_UNITS - 1)) ? '0 : rel_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own    <= '0;
      busy_q <= 1'b0;
      head   <= '0;
    end else if (rel) begin
      own    <= '0;
      busy_q <= 1'b0;
      head   <= next_head;
    end else if (take) begin
      own    <= pick;
      busy_q <= 1'b1;
    end
  end

  a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(own));
  a_r4_busy_match: assert property (@(posedge clk) disable iff (!rst_n) busy_q == (|own));
  a_r2_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && (|pick)) |=> busy_q);
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (|(own & done)) |=> (!busy_q && own == '0));
  a_r7_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (own & done) == '0) |=> ($stable(own) && busy_q));

  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_hold
      a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (own[i] && !done[i]) |=> own[i]);
    end
  endgenerate
endmodule

// File: rtl/rot_chain_arbiter.sv
module rot_chain_arbiter #(
  parameter int unsigned N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] req,
  input  logic [N_UNITS-1:0] done,
  output logic [N_UNITS-1:0] grant,
  output logic               busy
);
  localparam int unsigned IDX_W = rca_pkg::idx_bits(N_UNITS);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [IDX_W-1:0]   head;
  logic [N_UNITS-1:0] want;
  logic [N_UNITS-1:0] pick;

  assign want = req & ~grant;

  rca_ring #(.N_UNITS(N_UNITS)) u_ring (
    .head(head),
    .want(want),
    .pick(pick)
  );

  rca_owner #(.N_UNITS(N_UNITS)) u_owner (
    .clk   (clk),
    .rst_n (rst_n),
    .pick  (pick),
    .done  (done),
    .own   (grant),
    .busy_q(busy),
    .head  (head)
  );

  a_r3_pick_iff_want: assert property (@(posedge clk) disable iff (!rst_n)
    ((|want) == (|pick)) && $onehot0(pick) && ((pick & ~want) == '0));

  // R9 fairness window tracked by counters, one per unit
  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_fair
      logic [CNT_W-1:0] wait_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !req[i] || grant[i]) wait_cnt <= '0;
        else if (!busy && (|pick) && !pick[i]) wait_cnt <= wait_cnt + 1'b1;
      end
      a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CNT_W'(N_UNITS - 1));
    end
  endgenerate
endmodule

// File: tb/test_rot_chain_arbiter.sv
module test_rot_chain_arbiter;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] grant;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_own = -1;
  int m_head = 0;
  int waitc [N];

  rot_chain_arbiter #(.N_UNITS(N)) i_rot_chain_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .grant(grant), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic int first_from(input int h, input logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[(h + k) % N]) return (h + k) % N;
    return -1;
  endfunction

  function automatic logic [N-1:0] onehot(input int u);
    return (u < 0) ? '0 : (N'(1) << u);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, model one rising edge, compare at next negedge
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
    string tag;
    int    prev_own;
    bit    new_owner;
    req = r; done = d;
    prev_own = m_own;
    tag = "R5";
    if (m_own >= 0 && d[m_own]) begin
      m_head = (m_own + 1) % N;
      m_own = -1;
      tag = "R6";
    end else if (m_own < 0) begin
      m_own = first_from(m_head, r);
      tag = (m_own >= 0) ? "R3" : "R7";
    end else if (d != '0) tag = "R7";
    new_owner = (prev_own < 0) && (m_own >= 0);
    @(negedge clk);
    check(tag, grant, onehot(m_own));
    check("R4 busy", {{(N-1){1'b0}}, busy}, {{(N-1){1'b0}}, (m_own >= 0)});
    check("R4 onehot", {{(N-1){1'b0}}, $onehot0(grant)}, {{(N-1){1'b0}}, 1'b1});
    for (int i = 0; i < N; i++) begin
      if (!r[i] || grant[i]) waitc[i] = 0;
      else if (new_owner) waitc[i]++;
      if (waitc[i] > N - 1) begin
        errors++;
        $display("FAIL R9: unit %0d waited actual=%0d expected<=%0d", i, waitc[i], N - 1);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; done = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_own = -1; m_head = 0;
    for (int i = 0; i < N; i++) waitc[i] = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r, d;
    void'($urandom(32'd1234));
    do_reset();
    check("R1 grant", grant, '0);
    check("R1 busy", {{(N-1){1'b0}}, busy}, '0);
    step('1, '0);                       // R1: unit 0 heads the ring
    check("R1 head", grant, 4'b0001);
    step('1, 4'b0001);                  // R6 release, R8 head -> 1
    check("R6 idle", {{(N-1){1'b0}}, busy}, '0);
    step('1, '0);
    check("R8 next", grant, 4'b0010);
    step(4'b1001, 4'b1100);             // R7 stray done ignored, R5 hold
    check("R7 stray", grant, 4'b0010);
    step(4'b1001, 4'b0010);
    step(4'b1001, '0);                  // head 2 -> unit 3
    check("R3 skip", grant, 4'b1000);
    step(4'b0001, '0);                  // R5 owner 3 holds against unit 0
    check("R5 hold", grant, 4'b1000);
    step(4'b1001, 4'b1000);             // unit 3 releases
    step(4'b1001, '0);
    check("R10 wrap", grant, 4'b0001);
    step('0, 4'b0001);
    step('0, 4'b0110);                  // R7 done while idle
    check("R7 idle", {{(N-1){1'b0}}, busy}, '0);
    for (int n = 0; n < 3000; n++) begin
      r = N'($urandom);
      d = N'($urandom) & N'($urandom);
      if (m_own >= 0 && ($urandom % 3 == 0)) d[m_own] = 1'b1;
      step(r, d);
    end
    for (int n = 0; n < 400; n++) begin   // persistent requesters stress R9
      d = (m_own >= 0) ? onehot(m_own) : '0;
      step(4'b1111, ($urandom % 2) ? d : '0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule